// File: doc/BRIEF.md
# Deep Sleep Watchdog Timer with Wide-Range Postscaler

This block is a watchdog that lives in the always-on domain and counts only while the device is in deep sleep. When it expires it raises a wake flag that the wake-up logic picks up. A single enable bit turns it on. A 5-bit selector picks a time-out between a few milliseconds and several weeks. A one-bit source select chooses which slow clock drives it: the low-power RC clock or the secondary oscillator.

The slow clocks reach the block as one-cycle tick pulses in the fast clock domain, each with a ready level. On entry to deep sleep, an enabled watchdog latches its configuration, clears its counter and asks for its selected clock. It does this whether or not that clock is already running. Ticks are counted only while that clock reports ready, so a clock that has to start up simply delays the start of counting. Configuration that changes during deep sleep has no effect until the next entry.

Top module: `dsw_deep_sleep_wdt`

## Requirements
- R1: After reset, `wake_timeout`, `req_lprc` and `req_sosc` are all 0.
- R2: A `ds_enter` pulse clears the counter and the wake flag. `wake_timeout` reads 0 from the next cycle.
- R3: With selector n latched at entry, the wake flag sets at the clock edge that counts tick number 2^(CNT_W−n). For n > CNT_W−MIN_LOG2 the period is clamped to 2^MIN_LOG2 ticks. With the default CNT_W=36 and MIN_LOG2=6, the range runs from 2^6 to 2^36 ticks.
- R4: Once set, `wake_timeout` stays 1 through further ticks and through `ds_exit`. Only the next `ds_enter` clears it.
- R5: If `cfg_en` is 0 at entry, neither request output asserts and no number of ticks produces a time-out during that deep sleep period.
- R6: An enabled watchdog in deep sleep drives exactly one request: `req_lprc` when the latched source is 0, `req_sosc` when it is 1. The request holds until time-out or `ds_exit`, whatever the ready inputs show.
- R7: Only ticks of the selected source count, and only in cycles where that source's ready input is 1. Ticks of the other source and ticks while not ready are ignored.
- R8: `cfg_en`, `cfg_src` and `cfg_ps` are sampled only at `ds_enter`. Changing them during deep sleep alters neither the request nor the period.
- R9: After `ds_exit` the counter holds at zero, both requests drop and ticks cannot cause a time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Watchdog enable, sampled at entry |
| cfg_src | input | 1 | Clock source select: 0 low-power RC, 1 secondary oscillator |
| cfg_ps | input | PS_W | Postscale selector n, sampled at entry |
| lprc_rdy | input | 1 | Low-power RC clock is running and stable |
| lprc_tick | input | 1 | One-cycle pulse per low-power RC period |
| sosc_rdy | input | 1 | Secondary oscillator is running and stable |
| sosc_tick | input | 1 | One-cycle pulse per secondary oscillator period |
| ds_enter | input | 1 | Deep sleep entry strobe |
| ds_exit | input | 1 | Deep sleep exit strobe |
| req_lprc | output | 1 | Request to run the low-power RC clock |
| req_sosc | output | 1 | Request to run the secondary oscillator |
| wake_timeout | output | 1 | Sticky time-out wake flag |

## Verification
The latched tap decides the period, so a wrong tap index or a clamp error shows up as a wake flag that fires one or more octaves early or late. The bench's sweep over every selector value pins this to the exact tick. A counter that fails to clear at entry or exit shortens the next period, which shows up on the first short time-out after re-entry. A wrong latched source or enable shows up at once on the request outputs in the cycle after entry. A broken ready or source gate shows up as a time-out with too few qualified ticks.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE     = 2'd0,
    ST_SLEEP_OFF = 2'd1,
    ST_ARMED     = 2'd2,
    ST_EXPIRED   = 2'd3
  } dsw_state_e;

  typedef enum logic {
    SRC_LPRC = 1'b0,
    SRC_SOSC = 1'b1
  } dsw_src_e;

  // Counter bit whose first set marks the time-out for selector sel.
  function automatic int dsw_tap(input int sel, input int cnt_w, input int min_log2);
    int t;
    t = cnt_w - sel;
    if (t < min_log2) t = min_log2;
    if (t > cnt_w) t = cnt_w;
    return t;
  endfunction

endpackage

// File: rtl/dsw_cfg_latch.sv
module dsw_cfg_latch
  import dsw_pkg::*;
#(
  parameter int CNT_W    = 36,
  parameter int MIN_LOG2 = 6,
  parameter int PS_W     = 5,
  parameter int TAP_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ds_enter,
  input  logic             cfg_en,
  input  logic             cfg_src,
  input  logic [PS_W-1:0]  cfg_ps,
  output logic             en_lat,
  output dsw_src_e         src_lat,
  output logic [TAP_W-1:0] tap_lat
);

  logic [TAP_W-1:0] tap_new;

  always_comb tap_new = TAP_W'(dsw_tap(int'(cfg_ps), CNT_W, MIN_LOG2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lat  <= 1'b0;
      src_lat <= SRC_LPRC;
      tap_lat <= TAP_W'(CNT_W);
    end else if (ds_enter) begin
      en_lat  <= cfg_en;
      src_lat <= dsw_src_e'(cfg_src);
      tap_lat <= tap_new;
    end
  end

endmodule

// File: rtl/dsw_clk_sel.sv
module dsw_clk_sel
  import dsw_pkg::*;
(
  input  logic     armed,
  input  dsw_src_e src_lat,
  input  logic     lprc_rdy,
  input  logic     lprc_tick,
  input  logic     sosc_rdy,
  input  logic     sosc_tick,
  output logic     req_lprc,
  output logic     req_sosc,
  output logic     sel_tick
);

  logic [1:0] rdy_v;
  logic [1:0] tick_v;
  logic [1:0] req_v;

  assign rdy_v  = {sosc_rdy, lprc_rdy};
  assign tick_v = {sosc_tick, lprc_tick};

  for (genvar s = 0; s < 2; s++) begin : g_src
    assign req_v[s] = armed && (src_lat == dsw_src_e'(s));
  end

  assign req_lprc = req_v[0];
  assign req_sosc = req_v[1];
  assign sel_tick = tick_v[src_lat] & rdy_v[src_lat];

endmodule

// File: rtl/dsw_prescale.sv
module dsw_prescale #(
  parameter int CNT_W = 36,
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clr,
  input  logic             cnt_step,
  input  logic [TAP_W-1:0] tap,
  output logic [CNT_W:0]   cnt_val,
  output logic             hit
);

  logic [CNT_W:0] cnt_inc;

  assign cnt_inc = cnt_val + 1'b1;
  assign hit     = cnt_inc[tap];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_val <= '0;
    else if (cnt_clr)  cnt_val <= '0;
    else if (cnt_step) cnt_val <= cnt_inc;
  end

endmodule

// File: rtl/dsw_ctrl.sv
module dsw_ctrl
  import dsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ds_enter,
  input  logic ds_exit,
  input  logic cfg_en,
  input  logic sel_tick,
  input  logic hit,
  output logic in_ds,
  output logic armed,
  output logic cnt_clr,
  output logic cnt_step,
  output logic wake
);

  dsw_state_e state_q;
  logic       expire;

  assign in_ds    = (state_q != ST_AWAKE);
  assign armed    = (state_q == ST_ARMED);
  assign cnt_clr  = ds_enter | ds_exit;
  assign cnt_step = armed && sel_tick && !cnt_clr;
  assign expire   = cnt_step && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      wake    <= 1'b0;
    end else if (ds_enter) begin
      state_q <= cfg_en ? ST_ARMED : ST_SLEEP_OFF;
      wake    <= 1'b0;
    end else if (ds_exit) begin
      state_q <= ST_AWAKE;
    end else if (expire) begin
      state_q <= ST_EXPIRED;
      wake    <= 1'b1;
    end
  end

endmodule

// File: rtl/dsw_deep_sleep_wdt.sv
module dsw_deep_sleep_wdt
  import dsw_pkg::*;
#(
  parameter int CNT_W    = 36,
  parameter int MIN_LOG2 = 6,
  parameter int PS_W     = 5,
  parameter int TAP_W    = $clog2(CNT_W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_src,
  input  logic [PS_W-1:0] cfg_ps,
  input  logic            lprc_rdy,
  input  logic            lprc_tick,
  input  logic            sosc_rdy,
  input  logic            sosc_tick,
  input  logic            ds_enter,
  input  logic            ds_exit,
  output logic            req_lprc,
  output logic            req_sosc,
  output logic            wake_timeout
);

  logic             en_lat;
  dsw_src_e         src_lat;
  logic [TAP_W-1:0] tap_lat;
  logic             in_ds;
  logic             armed;
  logic             cnt_clr;
  logic             cnt_step;
  logic             sel_tick;
  logic             hit;
  logic [CNT_W:0]   cnt_val;

  dsw_cfg_latch #(
    .CNT_W(CNT_W), .MIN_LOG2(MIN_LOG2), .PS_W(PS_W), .TAP_W(TAP_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .ds_enter(ds_enter),
    .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_ps(cfg_ps),
    .en_lat(en_lat), .src_lat(src_lat), .tap_lat(tap_lat)
  );

  dsw_clk_sel u_sel (
    .armed(armed), .src_lat(src_lat),
    .lprc_rdy(lprc_rdy), .lprc_tick(lprc_tick),
    .sosc_rdy(sosc_rdy), .sosc_tick(sosc_tick),
    .req_lprc(req_lprc), .req_sosc(req_sosc), .sel_tick(sel_tick)
  );

  dsw_prescale #(.CNT_W(CNT_W), .TAP_W(TAP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .cnt_step(cnt_step),
    .tap(tap_lat), .cnt_val(cnt_val), .hit(hit)
  );

  dsw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ds_enter(ds_enter), .ds_exit(ds_exit),
    .cfg_en(cfg_en), .sel_tick(sel_tick), .hit(hit),
    .in_ds(in_ds), .armed(armed), .cnt_clr(cnt_clr), .cnt_step(cnt_step),
    .wake(wake_timeout)
  );

endmodule

// File: rtl/dsw_checker.sv
module dsw_checker #(
  parameter int CNT_W = 36
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ds_enter,
  input logic           ds_exit,
  input logic           wake_timeout,
  input logic           req_lprc,
  input logic           req_sosc,
  input logic           in_ds,
  input logic           en_lat,
  input logic           cnt_step,
  input logic [CNT_W:0] cnt_val
);

  AST_ENTRY_CLEARS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ds_enter |=> !wake_timeout); // R2

  AST_ENTRY_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ds_enter |=> (cnt_val == '0)); // R2

  AST_WAKE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_timeout) |-> $past(cnt_step)); // R3

  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_timeout && !ds_enter) |=> wake_timeout); // R4

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ds && !en_lat) |-> (!req_lprc && !req_sosc && cnt_val == '0)); // R5

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_lprc, req_sosc})); // R6

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_step && !ds_enter && !ds_exit) |=> $stable(cnt_val)); // R7

  AST_AWAKE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ds |-> (!req_lprc && !req_sosc && cnt_val == '0)); // R9

endmodule

bind dsw_deep_sleep_wdt dsw_checker #(.CNT_W(CNT_W)) u_dsw_chk (
  .clk(clk), .rst_n(rst_n), .ds_enter(ds_enter), .ds_exit(ds_exit),
  .wake_timeout(wake_timeout), .req_lprc(req_lprc), .req_sosc(req_sosc),
  .in_ds(in_ds), .en_lat(en_lat), .cnt_step(cnt_step), .cnt_val(cnt_val)
);

// File: tb/tb_dsw_deep_sleep_wdt.sv
module tb_dsw_deep_sleep_wdt;

  localparam int CNT_W    = 12;
  localparam int MIN_LOG2 = 3;
  localparam int PS_W     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_src = 1'b0;
  logic [PS_W-1:0] cfg_ps = '0;
  logic lprc_rdy = 1'b1, lprc_tick = 1'b0, sosc_rdy = 1'b1, sosc_tick = 1'b0;
  logic ds_enter = 1'b0, ds_exit = 1'b0;
  logic req_lprc, req_sosc, wake_timeout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsw_deep_sleep_wdt #(.CNT_W(CNT_W), .MIN_LOG2(MIN_LOG2), .PS_W(PS_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_ps(cfg_ps),
    .lprc_rdy(lprc_rdy), .lprc_tick(lprc_tick), .sosc_rdy(sosc_rdy), .sosc_tick(sosc_tick),
    .ds_enter(ds_enter), .ds_exit(ds_exit),
    .req_lprc(req_lprc), .req_sosc(req_sosc), .wake_timeout(wake_timeout)
  );

  function automatic int exp_period(int n);
    int shift;
    shift = (n > CNT_W - MIN_LOG2) ? MIN_LOG2 : CNT_W - n;
    return 1 << shift;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic enter(bit en, bit src, int ps);
    @(negedge clk);
    cfg_en = en; cfg_src = src; cfg_ps = PS_W'(ps); ds_enter = 1'b1;
    @(negedge clk);
    ds_enter = 1'b0;
  endtask

  task automatic leave();
    @(negedge clk); ds_exit = 1'b1;
    @(negedge clk); ds_exit = 1'b0;
  endtask

  task automatic ticks(bit which, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which) sosc_tick = 1'b1; else lprc_tick = 1'b1;
    end
    @(negedge clk);
    lprc_tick = 1'b0; sosc_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "wake after reset", wake_timeout, 1'b0);
    check("R1", "req_lprc after reset", req_lprc, 1'b0);
    check("R1", "req_sosc after reset", req_sosc, 1'b0);
    rst_n = 1'b1;

    // R3 sweep over every selector, alternating source
    for (int n = 0; n < 32; n++) begin
      enter(1'b1, n[0], n);
      ticks(n[0], exp_period(n) - 1);
      check("R3", $sformatf("no wake one tick early n=%0d", n), wake_timeout, 1'b0);
      ticks(n[0], 1);
      check("R3", $sformatf("wake on last tick n=%0d", n), wake_timeout, 1'b1);
    end

    // R4 / R6: sticky after expiry, requests dropped
    ticks(1'b1, 5);
    check("R4", "wake stays through ticks", wake_timeout, 1'b1);
    check("R6", "req_sosc dropped after expiry", req_sosc, 1'b0);
    leave();
    check("R4", "wake stays through exit", wake_timeout, 1'b1);
    check("R9", "req_lprc after exit", req_lprc, 1'b0);

    // R2 / R6: entry clears wake, request follows source
    enter(1'b1, 1'b0, 31);
    check("R2", "wake cleared by entry", wake_timeout, 1'b0);
    check("R6", "req_lprc for source 0", req_lprc, 1'b1);
    check("R6", "req_sosc for source 0", req_sosc, 1'b0);

    // R7: wrong source and not-ready ticks ignored
    ticks(1'b1, 20);
    check("R7", "other source ignored", wake_timeout, 1'b0);
    lprc_rdy = 1'b0;
    ticks(1'b0, 20);
    check("R7", "not-ready ticks ignored", wake_timeout, 1'b0);
    check("R6", "request held while not ready", req_lprc, 1'b1);
    lprc_rdy = 1'b1;
    ticks(1'b0, 7);
    check("R7", "no wake after 7 ready ticks", wake_timeout, 1'b0);
    ticks(1'b0, 1);
    check("R7", "wake after 8 ready ticks", wake_timeout, 1'b1);

    // R8: config changes during sleep ignored
    enter(1'b1, 1'b0, 31);
    @(negedge clk); cfg_en = 1'b0; cfg_src = 1'b1; cfg_ps = '0;
    check("R8", "req_lprc kept after cfg change", req_lprc, 1'b1);
    check("R8", "req_sosc stays low", req_sosc, 1'b0);
    ticks(1'b0, 8);
    check("R8", "old period applies", wake_timeout, 1'b1);

    // R5: disabled at entry
    enter(1'b0, 1'b0, 31);
    check("R5", "no req_lprc when disabled", req_lprc, 1'b0);
    check("R5", "no req_sosc when disabled", req_sosc, 1'b0);
    ticks(1'b0, 30);
    ticks(1'b1, 30);
    check("R5", "no wake when disabled", wake_timeout, 1'b0);

    // R9: exit mid-count, ticks ignored, re-entry restarts from zero
    enter(1'b1, 1'b1, 31);
    ticks(1'b1, 5);
    leave();
    check("R9", "req_sosc dropped on exit", req_sosc, 1'b0);
    ticks(1'b1, 20);
    check("R9", "ticks after exit ignored", wake_timeout, 1'b0);
    enter(1'b1, 1'b1, 31);
    ticks(1'b1, 7);
    check("R9", "count restarted at re-entry", wake_timeout, 1'b0);
    ticks(1'b1, 1);
    check("R9", "wake after full period", wake_timeout, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule